// File: doc/BRIEF.md
# Staged Power Clamp Sequencer

This block drives the 8-bit power-switch control word of one processor core. When the core's supply is opened, the word does not jump straight from closed to open. It walks through a fixed series of intermediate values instead, so that the in-rush current stays limited. Each value is held for a fixed dwell before the next one is applied. An all-ones word means the switch is closed and the core is unpowered. An all-zeros word means the switch is fully open.

A power controller issues open or close requests through a one-cycle request strobe with a direction bit. The block raises `busy` while it works and pulses `done` when it finishes. If an open request finds the switch already fully open, the block takes no steps. It completes at once and flags `already_open` together with `done`. A close request puts the word back to all-ones in a single step and then waits one dwell before it completes.

The dwell length is `DWELL_US * CYCLES_PER_US` clock cycles, with `DWELL_US` defaulting to 10.

Top module: `clamp_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `switch_word` is 0xFF, and `busy`, `done` and `already_open` are 0.
- R2: An open request (`req_on`=1) accepted while `switch_word` is not 0x00 drives the word through 0xFF, 0xFE, 0xF8, 0xF0 and 0x00, in that order. The first value appears in the cycle after acceptance.
- R3: Every value in the open ladder, including the final 0x00, is held for exactly DWELL = `DWELL_US*CYCLES_PER_US` cycles. `done` pulses in the cycle after the final dwell, which is 5*DWELL cycles after the first value appeared.
- R4: An open request accepted while `switch_word` is 0x00 leaves the word unchanged. `done` pulses in the cycle right after acceptance.
- R5: A close request (`req_on`=0) sets `switch_word` to 0xFF in the cycle after acceptance. `done` pulses DWELL cycles later. This holds even if the word was already 0xFF.
- R6: `busy` is high from the cycle after acceptance through the cycle in which `done` is high, and low otherwise. `done` is high for exactly one cycle per request.
- R7: While `busy` is high, a `req_valid` has no effect on the word sequence or on the completion timing.
- R8: `already_open` is high only together with the `done` of an open request that skipped the ladder. It is 0 for every other completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only while idle |
| req_on | input | 1 | Request direction: 1 opens the switch, 0 closes it |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| already_open | output | 1 | Pulses with done when an open request found the switch open |
| switch_word | output | 8 | Current power-switch control word |

## Verification
The directed cases cover four situations, each of which separates a different path: open from closed (full ladder), open from open (skip path), close from open, and close from already closed (which must still dwell). One open sequence is run with stray requests injected every cycle while busy, to show that nothing in flight can be redirected. A seeded random mix of open and close requests with random idle gaps then covers back-to-back starts and every transition between the open and closed states. In every cycle the bench compares the word, busy, done and the skip flag against a cycle-indexed model.

// File: rtl/pwr_clamp_pkg.sv
// Shared types for the power clamp sequencer.
// Assumes: a single core's switch, one request in flight at a time.
package pwr_clamp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } clamp_state_t;

    // Number of values in the open ladder.
    localparam int LADDER_LEN = 5;
endpackage

// File: rtl/clamp_ladder_rom.sv
// Maps a ladder index to the switch word applied at that step.
// Each step clears more low bits: 0, 1, 3, 4, then all of them.
// Assumes WORD_W >= 5; indices past the last step give all zeros.
module clamp_ladder_rom #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    localparam logic [WORD_W-1:0] ONES = '1;

    // Combinational step decode.
    always_comb begin
        case (idx)
            IDX_W'(0): word = ONES;
            IDX_W'(1): word = ONES << 1;
            IDX_W'(2): word = ONES << 3;
            IDX_W'(3): word = ONES << 4;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/dwell_timer.sv
// Down-counter that enforces the dwell of one step.
// A load sets the count to DWELL-1. expired is high in the last cycle
// of the dwell, so the owner advances on that edge.
// Assumes DWELL >= 1.
module dwell_timer #(
    parameter int DWELL = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(DWELL + 1);
    localparam logic [CNT_W-1:0] START = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= START;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);

    // R3: a fresh load always starts a full dwell
    a_r3_load_starts_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == START));
endmodule

// File: rtl/clamp_sequencer.sv
// Staged power clamp sequencer for one core's power switch.
// Accepts open and close requests while idle. An open request walks the
// switch word down a five-step ladder, holding each value for one dwell,
// unless the word is already all zeros. A close request returns the word
// to all ones and dwells once.
// Assumes: req_valid is a strobe and is ignored while busy.
module clamp_sequencer
    import pwr_clamp_pkg::*;
#(
    parameter int WORD_W        = 8,
    parameter int CYCLES_PER_US = 50,
    parameter int DWELL_US      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    output logic              busy,
    output logic              done,
    output logic              already_open,
    output logic [WORD_W-1:0] switch_word
);
    localparam int DWELL = DWELL_US * CYCLES_PER_US;
    localparam int IDX_W = $clog2(LADDER_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LADDER_LEN - 1);
    localparam logic [WORD_W-1:0] CLOSED = '1;

    clamp_state_t      state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_next;
    logic [WORD_W-1:0] next_word;
    logic              skip_q;
    logic              tmr_load;
    logic              tmr_expired;
    logic              is_open;
    logic              accept;

    assign idx_next = idx + IDX_W'(1);
    assign is_open  = (switch_word == '0);
    assign accept   = (state == ST_IDLE) && req_valid;

    clamp_ladder_rom #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_rom (
        .idx  (idx_next),
        .word (next_word)
    );

    // Start a dwell on each new step, but not on a skipped open.
    assign tmr_load = (accept && !(req_on && is_open)) ||
                      ((state == ST_STEP) && tmr_expired && (idx != LAST_IDX));

    dwell_timer #(.DWELL(DWELL)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    // Sequencer state, ladder index, switch word and skip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            switch_word <= CLOSED;
            skip_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    skip_q <= 1'b0;
                    if (req_valid) begin
                        if (req_on && is_open) begin
                            state  <= ST_DONE;
                            skip_q <= 1'b1;
                        end else begin
                            state       <= ST_STEP;
                            switch_word <= CLOSED;
                            idx         <= req_on ? '0 : LAST_IDX;
                        end
                    end
                end
                ST_STEP: begin
                    if (tmr_expired) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_DONE;
                        end else begin
                            idx         <= idx_next;
                            switch_word <= next_word;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    skip_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign done         = (state == ST_DONE);
    assign already_open = skip_q && done;

    // R6: done never appears outside a busy period
    a_r6_done_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the skip flag only appears with a completion
    a_r8_open_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        already_open |-> (done && switch_word == '0));
    // R2: leaving 0xFE while stepping can only lead to 0xF8
    a_r2_fe_then_f8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(switch_word) == WORD_W'(8'hFE) && switch_word != WORD_W'(8'hFE))
        |-> (switch_word == WORD_W'(8'hF8)));
    // R3: inside a sequence the word only moves when the dwell has ended
    a_r3_move_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_STEP && switch_word != $past(switch_word))
        |-> $past(tmr_expired));
    // R7: a request while busy does not restart the sequence
    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/test_clamp_sequencer.sv
module test_clamp_sequencer;
    localparam int CPU   = 2;
    localparam int DW    = 10 * CPU;
    localparam int NSTEP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_on = 1'b0;
    logic       busy, done, already_open;
    logic [7:0] switch_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model_word = 8'hFF;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    clamp_sequencer #(.WORD_W(8), .CYCLES_PER_US(CPU), .DWELL_US(10)) i_clamp_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_on       (req_on),
        .busy         (busy),
        .done         (done),
        .already_open (already_open),
        .switch_word  (switch_word)
    );

    function automatic logic [7:0] ladder(int i);
        case (i)
            0: return 8'hFF;
            1: return 8'hFE;
            2: return 8'hF8;
            3: return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Issue one request and check every cycle until one cycle after done.
    task automatic do_req(bit on, bit noise);
        bit   skip;
        int   len;
        logic [7:0] ew;
        string tw, tt;
        skip = on && (model_word == 8'h00);
        len  = skip ? 0 : (on ? NSTEP * DW : DW);
        tw   = noise ? "R7" : (skip ? "R4" : (on ? "R2" : "R5"));
        tt   = noise ? "R7" : (on ? "R3" : "R5");
        @(negedge clk);
        req_valid = 1'b1;
        req_on    = on;
        for (int k = 0; k <= len + 1; k++) begin
            @(negedge clk);
            if (skip)       ew = 8'h00;
            else if (!on)   ew = 8'hFF;
            else if (k < len) ew = ladder(k / DW);
            else            ew = 8'h00;
            chk(switch_word == ew, tw, "word", switch_word, ew);
            chk(done == (k == len), tt, "done", done, (k == len));
            chk(busy == (k <= len), "R6", "busy", busy, (k <= len));
            chk(already_open == (skip && k == len), "R8", "already_open",
                already_open, (skip && k == len));
            if (noise && k < len) begin
                req_valid = 1'b1;
                req_on    = $urandom_range(0, 1);
            end else begin
                req_valid = 1'b0;
            end
        end
        model_word = on ? 8'h00 : 8'hFF;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(switch_word == 8'hFF, "R1", "reset word", switch_word, 8'hFF);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(already_open == 1'b0, "R1", "reset already_open", already_open, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(1'b1, 1'b0);   // R2/R3 full ladder from closed
        do_req(1'b1, 1'b0);   // R4 skip when already open
        do_req(1'b0, 1'b0);   // R5 close from open
        do_req(1'b0, 1'b0);   // R5 close when already closed
        do_req(1'b1, 1'b1);   // R7 open with stray requests while busy
        do_req(1'b0, 1'b1);   // R7 close with stray requests while busy
        for (int i = 0; i < 40; i++) begin
            int gap;
            gap = $urandom_range(0, 3);
            repeat (gap) @(negedge clk);
            do_req(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule